// File: doc/BRIEF.md
# General-Purpose Port Data Registers

This block holds the data registers of one general-purpose I/O port with up to sixteen pins. Pin levels pass through a two-stage synchronizer, and software reads them through a read-only input word. A read/write output word drives the output-data lines toward the pads. A third word is write-only and exists for atomic bit updates. Each 1 written to its low half sets an output bit, and each 1 written to its high half clears one. Bits written as 0 have no effect, so software can change single outputs without a read-modify-write sequence.

The bus side is a simple word slave. It takes a byte address, a write enable, write data and byte strobes, and it returns read data combinationally in the same cycle. The block decodes bits 2 and up of the address, so the two lowest address bits are ignored. The input word must be accessed as a whole word. A read of it with any other strobe pattern returns zero, and writes to it have no effect.

Top module: `gpio_data_port`

## Requirements
- R1: While reset is high and on the first cycle after it, the output word, `out_data` and every readable location are all zero.
- R2: A full-word read (`bus_strb` = 4'b1111) at byte offset 0x10 returns in bits NPINS-1:0 the values that `pin_in` had two rising clock edges earlier.
- R3: Bits 31:NPINS of the input word read as zero. A write to offset 0x10 changes neither the output word nor the input word.
- R4: A read at offset 0x10 whose `bus_strb` is not 4'b1111 returns zero.
- R5: A write at offset 0x14 updates the output word only in the enabled byte lanes. `bus_strb[0]` covers bits 7:0 and `bus_strb[1]` covers bits 15:8. With no write, the word holds its value.
- R6: A read at offset 0x14 returns the output word in bits NPINS-1:0 and zero above them, whatever the strobes are. `out_data` always equals the output word.
- R7: A write at offset 0x18 with bit y (y < NPINS) at 1 sets output bit y, if that bit's byte lane is enabled (`bus_strb[0]` for bits 7:0, `bus_strb[1]` for bits 15:8).
- R8: A write at offset 0x18 with bit y+16 at 1 clears output bit y, if that bit's byte lane is enabled (`bus_strb[2]` for bits 23:16, `bus_strb[3]` for bits 31:24).
- R9: In a write at offset 0x18, output bits whose set and clear bits are both 0, or fall in a disabled lane, keep their value.
- R10: When one write at offset 0x18 requests both a set and a clear of the same bit, that bit ends at 1.
- R11: Reads at offset 0x18 return zero.
- R12: Reads at offsets 0x00, 0x04, 0x08, 0x0C and 0x1C return zero, and writes there leave the output word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes; bit i covers data bits 8i+7:8i |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NPINS | Asynchronous pin levels |
| out_data | output | NPINS | Output word driven toward the pads |

## Verification
The bench builds the block with its defaults: NPINS = 16, so all sixteen set/clear pairs and both upper lanes are live, and ADDR_W = 5, so every one of the eight word slots in the address space can be visited. At this size the bench can walk a single one across every pin and every set/clear bit. It can also apply all sixteen strobe patterns to many data words on both writable offsets, and it can cover every partial-strobe read of the input word. For each write, the bench works out the expected output word by applying the lane masks to a model, so any mistake in lane gating or in set/clear priority appears as a mismatch.

// File: rtl/gpio_dreg_pkg.sv
package gpio_dreg_pkg;

    localparam int BUS_W      = 32;
    localparam int HALF_W     = 16;
    localparam int STRB_W     = BUS_W / 8;
    localparam int SYNC_DEPTH = 2;

    localparam logic [31:0] OFS_IN     = 32'h10;
    localparam logic [31:0] OFS_OUT    = 32'h14;
    localparam logic [31:0] OFS_SETCLR = 32'h18;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_IN,
        SEL_OUT,
        SEL_SETCLR
    } reg_sel_e;

    typedef struct packed {
        logic [HALF_W-1:0] clr;
        logic [HALF_W-1:0] set;
    } setclr_t;

    function automatic reg_sel_e decode_sel(input logic [31:0] byte_addr);
        logic [31:0] word_addr;
        word_addr = {byte_addr[31:2], 2'b00};
        case (word_addr)
            OFS_IN:     return SEL_IN;
            OFS_OUT:    return SEL_OUT;
            OFS_SETCLR: return SEL_SETCLR;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(input logic [STRB_W-1:0] strb);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < STRB_W; i++) begin
            m[8*i +: 8] = {8{strb[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_dreg_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] synced
);

    logic [SYNC_DEPTH-1:0][NPINS-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < SYNC_DEPTH; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // The last synchronizer stage doubles as the input data word.
    assign synced = stage_q[SYNC_DEPTH-1];

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
    import gpio_dreg_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_out,
    input  logic             wr_setclr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] lane,
    output logic [NPINS-1:0] odr_q
);

    setclr_t          req;
    logic [NPINS-1:0] set_v;
    logic [NPINS-1:0] clr_v;
    logic [NPINS-1:0] wmask;

    always_comb begin
        req.set = wdata[HALF_W-1:0]     & lane[HALF_W-1:0];
        req.clr = wdata[BUS_W-1:HALF_W] & lane[BUS_W-1:HALF_W];
        set_v   = req.set[NPINS-1:0];
        clr_v   = req.clr[NPINS-1:0];
        wmask   = lane[NPINS-1:0];
    end

    // Clear is applied first and set last, so a set request wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            odr_q <= '0;
        end else if (wr_out) begin
            odr_q <= (odr_q & ~wmask) | (wdata[NPINS-1:0] & wmask);
        end else if (wr_setclr) begin
            odr_q <= (odr_q & ~clr_v) | set_v;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (odr_q == '0));

    a_r7_set_applies: assert property (@(posedge clk) disable iff (rst)
        wr_setclr |=> ((odr_q & $past(wdata[NPINS-1:0] & lane[NPINS-1:0]))
                       == $past(wdata[NPINS-1:0] & lane[NPINS-1:0])));

    a_r8_clear_applies: assert property (@(posedge clk) disable iff (rst)
        wr_setclr |=> ((odr_q & $past(wdata[HALF_W +: NPINS] & lane[HALF_W +: NPINS]
                                      & ~(wdata[NPINS-1:0] & lane[NPINS-1:0]))) == '0));

    a_r9_untouched_hold: assert property (@(posedge clk) disable iff (rst)
        wr_setclr |=> (((odr_q ^ $past(odr_q))
                        & ~$past((wdata[NPINS-1:0] & lane[NPINS-1:0])
                                 | (wdata[HALF_W +: NPINS] & lane[HALF_W +: NPINS]))) == '0));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_out && !wr_setclr) |=> $stable(odr_q));

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_dreg_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  reg_sel_e          sel,
    input  logic [STRB_W-1:0] strb,
    input  logic [NPINS-1:0]  in_word,
    input  logic [NPINS-1:0]  out_word,
    output logic [BUS_W-1:0]  rdata
);

    localparam logic [STRB_W-1:0] FULL_STRB = '1;

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_IN: begin
                if (strb == FULL_STRB) begin
                    rdata[NPINS-1:0] = in_word;
                end
            end
            SEL_OUT:    rdata[NPINS-1:0] = out_word;
            SEL_SETCLR: rdata = '0;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
    import gpio_dreg_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_strb,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  out_data
);

    reg_sel_e         sel;
    logic [BUS_W-1:0] lane;
    logic             wr_out;
    logic             wr_setclr;
    logic [NPINS-1:0] in_word;
    logic [NPINS-1:0] odr_q;
    logic [1:0]       warm_q;

    always_comb begin
        sel       = decode_sel(32'(bus_addr));
        lane      = lane_mask(bus_strb);
        wr_out    = bus_wr && (sel == SEL_OUT);
        wr_setclr = bus_wr && (sel == SEL_SETCLR);
    end

    gpio_pin_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .synced (in_word)
    );

    gpio_out_reg #(.NPINS(NPINS)) u_out (
        .clk       (clk),
        .rst       (rst),
        .wr_out    (wr_out),
        .wr_setclr (wr_setclr),
        .wdata     (bus_wdata),
        .lane      (lane),
        .odr_q     (odr_q)
    );

    gpio_rd_mux #(.NPINS(NPINS)) u_rd (
        .sel      (sel),
        .strb     (bus_strb),
        .in_word  (in_word),
        .out_word (odr_q),
        .rdata    (bus_rdata)
    );

    assign out_data = odr_q;

    // Counts edges since reset so the pin-lag check looks only at valid history.
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    a_r2_pin_lag: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (in_word == $past(pin_in, 2)));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_IN) |-> (bus_rdata[BUS_W-1:NPINS] == '0));

    a_r4_partial_in_zero: assert property (@(posedge clk) disable iff (rst)
        ((sel == SEL_IN) && (bus_strb != 4'hF)) |-> (bus_rdata == '0));

    a_r6_out_readback: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_OUT) |-> (bus_rdata[NPINS-1:0] == out_data));

    a_r11_setclr_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SETCLR) |-> (bus_rdata == '0));

    a_r12_dead_write_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ((sel == SEL_NONE) || (sel == SEL_IN))) |=> $stable(out_data));

endmodule

// File: tb/tb_gpio_data_port.sv
module tb_gpio_data_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] model;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    gpio_data_port #(.NPINS(16), .ADDR_W(5)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] s);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{s[i]}};
        return m;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        return x * 32'h0019_660D + 32'h3C6E_F35F;
    endfunction

    task automatic rd(input logic [4:0] a, input logic [3:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_strb = s; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_strb = s; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic model_out(input logic [31:0] d, input logic [3:0] s);
        logic [31:0] l;
        l = lanes(s);
        model = (model & ~l[15:0]) | (d[15:0] & l[15:0]);
    endtask

    task automatic model_sc(input logic [31:0] d, input logic [3:0] s);
        logic [31:0] l;
        l = lanes(s);
        model = (model & ~(d[31:16] & l[31:16])) | (d[15:0] & l[15:0]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [15:0] prev;
        logic [15:0] p;
        model = '0;

        // R1: reset values
        repeat (2) @(posedge clk);
        #1 chk("R1 out_data in reset", {16'h0, out_data}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        rd(5'h14, 4'hF, d); chk("R1 output word", d, 32'h0);
        rd(5'h10, 4'hF, d); chk("R1 input word", d, 32'h0);
        rd(5'h18, 4'hF, d); chk("R1 set/clear word", d, 32'h0);
        chk("R1 out_data", {16'h0, out_data}, 32'h0);

        // R2: walking one over the pins, then pseudo-random patterns, two-edge lag
        prev = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < 16) p = 16'h1 << i;
            else begin seed = next_rand(seed); p = seed[23:8]; end
            @(negedge clk);
            pin_in = p;
            rd(5'h10, 4'hF, d); chk("R2 one edge after change", d, {16'h0, prev});
            rd(5'h10, 4'hF, d); chk("R2 two edges after change", d, {16'h0, p});
            prev = p;
        end

        // R4: every partial strobe pattern on the input word
        for (int s = 0; s < 15; s++) begin
            rd(5'h10, 4'(s), d); chk("R4 partial read of input word", d, 32'h0);
        end

        // R3: writes to the input word are ignored
        wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        rd(5'h14, 4'hF, d); chk("R3 output word after input write", d, {16'h0, model});
        rd(5'h10, 4'hF, d); chk("R3 input word after write", d, {16'h0, prev});

        // R5, R6: output word across patterns and all strobes
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 16; s++) begin
                seed = next_rand(seed);
                wr(5'h14, seed, 4'(s));
                model_out(seed, 4'(s));
                chk("R6 out_data follows output word", {16'h0, out_data}, {16'h0, model});
                rd(5'h14, 4'(15 - s), d);
                chk("R5 output word lanes", d, {16'h0, model});
            end
        end

        // R7 and R8: single set then single clear of each bit
        wr(5'h14, 32'h0, 4'hF); model = '0;
        for (int y = 0; y < 16; y++) begin
            wr(5'h18, 32'h1 << y, 4'hF); model_sc(32'h1 << y, 4'hF);
            chk("R7 set one bit", {16'h0, out_data}, {16'h0, model});
        end
        for (int y = 0; y < 16; y++) begin
            wr(5'h18, 32'h1 << (y + 16), 4'hF); model_sc(32'h1 << (y + 16), 4'hF);
            chk("R8 clear one bit", {16'h0, out_data}, {16'h0, model});
        end

        // R9: random set/clear words across all strobes, untouched bits held
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 16; s++) begin
                seed = next_rand(seed);
                wr(5'h18, seed, 4'(s));
                model_sc(seed, 4'(s));
                chk("R9 set/clear with lanes", {16'h0, out_data}, {16'h0, model});
            end
        end

        // R10: simultaneous set and clear, from zero and from ones
        for (int y = 0; y < 16; y++) begin
            wr(5'h14, 32'h0, 4'hF); model = '0;
            wr(5'h18, (32'h1 << y) | (32'h1 << (y + 16)), 4'hF);
            chk("R10 set wins from zero", {16'h0, out_data}, {16'h0, 16'h1 << y});
            wr(5'h14, 32'hFFFF, 4'hF);
            wr(5'h18, 32'hFFFF_0000 | (32'h1 << y), 4'hF);
            chk("R10 set wins among clears", {16'h0, out_data}, {16'h0, 16'h1 << y});
        end
        model = 16'h1 << 15;

        // R11: set/clear word reads zero
        for (int s = 0; s < 16; s++) begin
            rd(5'h18, 4'(s), d); chk("R11 set/clear read", d, 32'h0);
        end

        // R12: unmapped word slots
        wr(5'h14, 32'h0000_A5C3, 4'hF); model = 16'hA5C3;
        for (int a = 0; a < 8; a++) begin
            if (a >= 4 && a <= 6) continue;
            wr(5'(a * 4), 32'hFFFF_FFFF, 4'hF);
            rd(5'(a * 4), 4'hF, d); chk("R12 unmapped read", d, 32'h0);
            chk("R12 unmapped write ignored", {16'h0, out_data}, {16'h0, model});
        end

        finish_run();
    end

endmodule